// File: doc/BRIEF.md
# Pipelined Bus Request Enqueuer

This block is the master side of a split-transaction bus. It buffers read and write requests, each an address and a command code, in a small local queue. When the arbiter starts an operation, the block moves a burst of those requests onto the shared address/command lines, one request per clock, and marks each one with an active-low pipe strobe. The arbiter starts an operation by asserting the grant with a non-idle status code. The target reports how many request slots it has free. The block enqueues as many requests as both the queue and the target allow.

The active-low request line does two jobs. Between operations it asks for the bus while the queue holds entries. During a burst it tells the target that more requests follow, and it goes high on the final request. A small delay setting lets the master hold off the first strobe for up to two clocks after the start.

Top module: `pipe_req_enq`

## Requirements
- R1: While reset is active and after it is released, `pipe_n` and `req_n` are high, `push_ready` is high, and `bus_ad` and `bus_cmd` are zero.
- R2: A start is a clock edge that samples `gnt_n` low and `bus_stat` different from 3'b111. Let L be the effective delay, equal to `lat_cfg` clamped to at most 2. `pipe_n` is high for the first L cycles after that edge and goes low in cycle L+1.
- R3: In each cycle with `pipe_n` low, exactly one queue entry is consumed. Entries leave in the order they were pushed, and `bus_ad`/`bus_cmd` show the address and command of the entry being consumed.
- R4: An operation issues N = min(queue entries, `free_slots`) requests, both values taken at the start edge. `pipe_n` is low for exactly N consecutive cycles.
- R5: `req_n` is low in strobe cycles 1 to N-1 and high in strobe cycle N. `pipe_n` is high in the cycle after the one where `req_n` is high with the strobe active.
- R6: No strobe follows an edge where the status is 3'b111, where `gnt_n` is high, or where N would be 0. A start that arrives while an operation is in its delay or strobe phase is ignored.
- R7: Outside strobe cycles, `req_n` is low exactly when the queue holds at least one entry, and `bus_ad`/`bus_cmd` are zero.
- R8: A push is accepted on an edge with `push_valid` high and the queue not full, and `push_ready` equals "queue not full". A push offered while the queue is full is dropped. Entries not issued by an operation stay queued, in order, for a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Offer a request to the queue |
| push_addr | input | ADDR_W | Address of the offered request |
| push_cmd | input | CMD_W | Command code of the offered request |
| push_ready | output | 1 | Queue can accept a request |
| gnt_n | input | 1 | Bus grant, active low |
| bus_stat | input | 3 | Arbiter status; 3'b111 means idle |
| free_slots | input | SLOT_W | Request slots free at the target |
| lat_cfg | input | LAT_W | Start-to-strobe delay setting, clamped to 2 |
| pipe_n | output | 1 | Pipe strobe, active low, one request per low cycle |
| req_n | output | 1 | Bus request / more-follow flag, active low |
| bus_ad | output | ADDR_W | Address being enqueued |
| bus_cmd | output | CMD_W | Command being enqueued |

## Verification
The bench builds the block with a four-entry queue, 16-bit addresses and a 3-bit slot count, so that queue fill, slot count and delay setting can all be swept exhaustively. The sweep covers fill levels 0 to 4, slot counts 0 to 7 and delay settings 0 to 3. This reaches the empty, full and zero-slot corners, every choice between the queue limit and the slot limit, and the clamped delay. A follow-up operation in each case confirms that leftover entries keep their order. Directed cases check an overfull push, a restart during a running operation, and an idle status with the grant asserted.

// File: rtl/pipe_enq_pkg.sv
`timescale 1ns/1ps
package pipe_enq_pkg;
    localparam logic [2:0] STAT_IDLE = 3'b111;
    localparam int         MAX_LAT   = 2;
    localparam int         LW        = $clog2(MAX_LAT + 1);

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_ISSUE = 2'd2
    } sq_state_e;
endpackage

// File: rtl/enq_fifo.sv
`timescale 1ns/1ps
module enq_fifo #(
    parameter  int W      = 8,
    parameter  int DEPTH  = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_wr, do_rd;

    assign full    = (int'(f_q.cnt) == DEPTH);
    assign empty   = (f_q.cnt == '0);
    assign count   = f_q.cnt;
    assign rd_data = f_q.mem[f_q.rp];

    always_comb begin
        f_d   = f_q;
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        if (do_wr) begin
            f_d.mem[f_q.wp] = wr_data;
            f_d.wp = (int'(f_q.wp) == DEPTH - 1) ? '0 : f_q.wp + 1'b1;
        end
        if (do_rd) begin
            f_d.rp = (int'(f_q.rp) == DEPTH - 1) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/enq_launch.sv
`timescale 1ns/1ps
module enq_launch
    import pipe_enq_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 4,
    parameter int LAT_W  = 2
) (
    input  logic              gnt_n,
    input  logic [2:0]        bus_stat,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [SLOT_W-1:0] free_slots,
    input  logic [LAT_W-1:0]  lat_cfg,
    output logic              start,
    output logic [CNT_W-1:0]  n_issue,
    output logic [LW-1:0]     lat_eff
);
    always_comb begin
        start = !gnt_n && (bus_stat != STAT_IDLE);
        if (int'(fifo_cnt) < int'(free_slots)) n_issue = fifo_cnt;
        else                                   n_issue = CNT_W'(free_slots);
        if (int'(lat_cfg) > MAX_LAT) lat_eff = LW'(MAX_LAT);
        else                         lat_eff = LW'(lat_cfg);
    end
endmodule

// File: rtl/enq_seq.sv
`timescale 1ns/1ps
module enq_seq
    import pipe_enq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] n_issue,
    input  logic [LW-1:0]    lat_eff,
    output logic             issuing,
    output logic             last,
    output sq_state_e        state
);
    typedef struct packed {
        sq_state_e        st;
        logic [LW-1:0]    wcnt;
        logic [CNT_W-1:0] remain;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start && (n_issue != '0)) begin
                    s_d.remain = n_issue;
                    s_d.wcnt   = lat_eff;
                    s_d.st     = (lat_eff == '0) ? SQ_ISSUE : SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                s_d.wcnt = s_q.wcnt - 1'b1;
                if (s_q.wcnt == LW'(1)) s_d.st = SQ_ISSUE;
            end
            SQ_ISSUE: begin
                s_d.remain = s_q.remain - 1'b1;
                if (s_q.remain == CNT_W'(1)) s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, wcnt: '0, remain: '0};
        else        s_q <= s_d;
    end

    assign issuing = (s_q.st == SQ_ISSUE);
    assign last    = issuing && (s_q.remain == CNT_W'(1));
    assign state   = s_q.st;
endmodule

// File: rtl/pipe_req_enq.sv
`timescale 1ns/1ps
module pipe_req_enq
    import pipe_enq_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int CMD_W  = 4,
    parameter  int DEPTH  = 8,
    parameter  int SLOT_W = 4,
    parameter  int LAT_W  = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ENT_W  = ADDR_W + CMD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [CMD_W-1:0]  push_cmd,
    output logic              push_ready,
    input  logic              gnt_n,
    input  logic [2:0]        bus_stat,
    input  logic [SLOT_W-1:0] free_slots,
    input  logic [LAT_W-1:0]  lat_cfg,
    output logic              pipe_n,
    output logic              req_n,
    output logic [ADDR_W-1:0] bus_ad,
    output logic [CMD_W-1:0]  bus_cmd
);
    logic             fifo_full, fifo_empty, push_fire;
    logic [CNT_W-1:0] fifo_cnt, n_issue;
    logic [ENT_W-1:0] head;
    logic             start, issuing, last;
    logic [LW-1:0]    lat_eff;
    sq_state_e        seq_st;

    assign push_ready = !fifo_full;
    assign push_fire  = push_valid && !fifo_full;

    enq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_valid),
        .wr_data ({push_addr, push_cmd}),
        .rd_en   (issuing),
        .rd_data (head),
        .count   (fifo_cnt),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    enq_launch #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .LAT_W(LAT_W)) u_launch (
        .gnt_n      (gnt_n),
        .bus_stat   (bus_stat),
        .fifo_cnt   (fifo_cnt),
        .free_slots (free_slots),
        .lat_cfg    (lat_cfg),
        .start      (start),
        .n_issue    (n_issue),
        .lat_eff    (lat_eff)
    );

    enq_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .n_issue (n_issue),
        .lat_eff (lat_eff),
        .issuing (issuing),
        .last    (last),
        .state   (seq_st)
    );

    always_comb begin
        pipe_n = !issuing;
        if (issuing) begin
            req_n   = last;
            bus_ad  = head[ENT_W-1:CMD_W];
            bus_cmd = head[CMD_W-1:0];
        end else begin
            req_n   = fifo_empty;
            bus_ad  = '0;
            bus_cmd = '0;
        end
    end
endmodule

// File: rtl/pipe_enq_chk.sv
`timescale 1ns/1ps
module pipe_enq_chk
    import pipe_enq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pipe_n,
    input logic             req_n,
    input logic             push_fire,
    input logic [CNT_W-1:0] fifo_cnt,
    input sq_state_e        seq_st
);
    logic [2:0] wait_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wait_run <= '0;
        else if (seq_st != SQ_WAIT) wait_run <= '0;
        else if (wait_run != 3'd7)  wait_run <= wait_run + 1'b1;
    end

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= 3'd2); // R2

    AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_n && !push_fire) |=> (fifo_cnt == CNT_W'($past(fifo_cnt) - 1'b1))); // R3

    AST_STROBE_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_n |-> (fifo_cnt != '0)); // R4

    AST_STROBE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_n && req_n) |=> pipe_n); // R5

    AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_n && (seq_st == SQ_IDLE)) |-> (req_n == (fifo_cnt == '0))); // R7
endmodule

bind pipe_req_enq pipe_enq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_n    (pipe_n),
    .req_n     (req_n),
    .push_fire (push_fire),
    .fifo_cnt  (fifo_cnt),
    .seq_st    (seq_st)
);

// File: tb/pipe_req_enq_bench.sv
`timescale 1ns/1ps
module pipe_req_enq_bench;
    localparam int ADDR_W = 16;
    localparam int CMD_W  = 4;
    localparam int DEPTH  = 4;
    localparam int SLOT_W = 3;
    localparam int LAT_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_valid;
    logic [ADDR_W-1:0] push_addr;
    logic [CMD_W-1:0]  push_cmd;
    logic              push_ready;
    logic              gnt_n;
    logic [2:0]        bus_stat;
    logic [SLOT_W-1:0] free_slots;
    logic [LAT_W-1:0]  lat_cfg;
    logic              pipe_n, req_n;
    logic [ADDR_W-1:0] bus_ad;
    logic [CMD_W-1:0]  bus_cmd;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    pipe_req_enq #(
        .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DEPTH(DEPTH),
        .SLOT_W(SLOT_W), .LAT_W(LAT_W)
    ) u_pipe_req_enq (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
        .push_cmd(push_cmd), .push_ready(push_ready), .gnt_n(gnt_n),
        .bus_stat(bus_stat), .free_slots(free_slots), .lat_cfg(lat_cfg),
        .pipe_n(pipe_n), .req_n(req_n), .bus_ad(bus_ad), .bus_cmd(bus_cmd)
    );

    function automatic logic [ADDR_W-1:0] addr_of(input int tag, input int i);
        return ADDR_W'(tag * 16 + i + 16'h1000);
    endfunction

    function automatic logic [CMD_W-1:0] cmd_of(input int tag, input int i);
        return CMD_W'(tag + 3 * i);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; push_valid = 1'b0; push_addr = '0; push_cmd = '0;
        gnt_n = 1'b1; bus_stat = 3'b111; free_slots = '0; lat_cfg = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // pushes n entries with index first..first+n-1; ends at a negedge with valid low
    task automatic do_push(input int tag, input int first, input int n);
        for (int i = 0; i < n; i++) begin
            push_valid = 1'b1;
            push_addr  = addr_of(tag, first + i);
            push_cmd   = cmd_of(tag, first + i);
            @(negedge clk);
        end
        push_valid = 1'b0;
    endtask

    // one operation attempt; expects exp_n strobes after exp_l idle cycles
    task automatic do_op(input int f, input int lat, input logic g, input logic [2:0] st,
                         input int exp_n, input int exp_l, input int tag, input int first);
        free_slots = SLOT_W'(f);
        lat_cfg    = LAT_W'(lat);
        gnt_n      = g;
        bus_stat   = st;
        @(negedge clk);
        gnt_n    = 1'b1;
        bus_stat = 3'b111;
        for (int c = 0; c < exp_l + exp_n + 2; c++) begin
            int  idx;
            bit  iss;
            if (c > 0) @(negedge clk);
            idx = c - exp_l;
            iss = (c >= exp_l) && (idx < exp_n);
            chk(iss ? "R2/R4 strobe low" : "R2/R4/R6 strobe high", int'(pipe_n), iss ? 0 : 1);
            if (iss) begin
                chk("R3 address", int'(bus_ad), int'(addr_of(tag, first + idx)));
                chk("R3 command", int'(bus_cmd), int'(cmd_of(tag, first + idx)));
                chk("R5 more-follow flag", int'(req_n), (idx == exp_n - 1) ? 1 : 0);
            end else begin
                chk("R7 address zero", int'(bus_ad), 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int tag = 0;
        do_reset();
        // R1: reset state
        chk("R1 pipe_n", int'(pipe_n), 1);
        chk("R1 req_n", int'(req_n), 1);
        chk("R1 push_ready", int'(push_ready), 1);
        chk("R1 bus_ad", int'(bus_ad), 0);
        chk("R1 bus_cmd", int'(bus_cmd), 0);

        // Exhaustive sweep: fill k, slots f, delay l
        for (int k = 0; k <= DEPTH; k++) begin
            for (int f = 0; f < (1 << SLOT_W); f++) begin
                for (int l = 0; l < (1 << LAT_W); l++) begin
                    int n, el;
                    tag = (tag + 1) & 15;
                    n  = (k < f) ? k : f;
                    el = (l > 2) ? 2 : l;
                    do_reset();
                    do_push(tag, 0, k);
                    chk("R8 push_ready", int'(push_ready), (k < DEPTH) ? 1 : 0);
                    chk("R7 idle request", int'(req_n), (k == 0) ? 1 : 0);
                    // R6: idle status with grant asserted starts nothing
                    do_op(f, l, 1'b0, 3'b111, 0, 0, tag, 0);
                    // main operation
                    do_op(f, l, 1'b0, 3'b010, n, el, tag, 0);
                    chk("R7 request after op", int'(req_n), (k - n == 0) ? 1 : 0);
                    // R8: leftovers keep order for the next operation
                    do_op(7, 0, 1'b0, 3'b001, k - n, 0, tag, n);
                end
            end
        end

        // R8: overfull push dropped
        do_reset();
        do_push(5, 0, DEPTH + 1);
        chk("R8 full push_ready", int'(push_ready), 0);
        do_op(7, 1, 1'b0, 3'b000, DEPTH, 1, 5, 0);
        chk("R8 dropped entry absent", int'(req_n), 1);

        // R6: restart during a running operation ignored
        do_reset();
        do_push(9, 0, DEPTH);
        free_slots = 3'd2; lat_cfg = 2'd2; gnt_n = 1'b0; bus_stat = 3'b011;
        @(negedge clk);                         // start sampled; now in delay
        chk("R6 delay cycle 1", int'(pipe_n), 1);
        free_slots = 3'd7; lat_cfg = 2'd0;      // start still asserted
        @(negedge clk);
        chk("R6 delay cycle 2", int'(pipe_n), 1);
        @(negedge clk);
        chk("R6 first strobe", int'(pipe_n), 0);
        chk("R6 first address", int'(bus_ad), int'(addr_of(9, 0)));
        gnt_n = 1'b1; bus_stat = 3'b111;
        @(negedge clk);
        chk("R6 second strobe last", int'(req_n), 1);
        chk("R6 second address", int'(bus_ad), int'(addr_of(9, 1)));
        @(negedge clk);
        chk("R6 no extra strobe", int'(pipe_n), 1);
        @(negedge clk);
        chk("R6 still idle", int'(pipe_n), 1);
        do_op(7, 0, 1'b0, 3'b100, 2, 0, 9, 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule